// File: doc/BRIEF.md
# Timestamped sample cluster expander

This block turns clusters read back from a logic-capture memory into a flat stream of 16-bit samples. A cluster starts with a 16-bit timestamp and carries up to seven event words. The capture side only stores a cluster when the inputs change, so idle time shows up only as a jump in the timestamps. The expander keeps track of the timestamp it expects next. When a cluster arrives later than expected, it first emits the missing samples as copies of the last sample it produced. It then unpacks the cluster's events.

The sample-rate mode sets how each event is unpacked. In the normal mode an event is one 16-bit sample. In the double-rate mode an event holds two 8-bit samples, and in the quad-rate mode it holds four 4-bit samples. In both fast modes the bits of the narrow samples are interleaved inside the event word. Padding in a fast mode is scaled to match, so each missing event becomes two or four repeated samples. The cluster stream and the sample stream both use valid/ready handshakes. Backpressure on the output stalls padding and unpacking alike.

Top module: `cluster_expander`

## Requirements
- R1: After reset `smp_valid` is 0 and `cl_ready` is 1.
- R2: A header word is marked by `cl_head` and holds the timestamp, with its high byte in bits 15:8. If `cl_start` is 1 on a header, the block loads the expected timestamp from that header, clears the last sample to 0, and emits no padding.
- R3: An event word arrives with its two bytes swapped. In mode 0, each event produces one sample equal to `{cl_word[7:0], cl_word[15:8]}`.
- R4: For a header without `cl_start`, the gap is (timestamp − expected) mod 2^16. The block emits gap × (samples per event) copies of the last sample before any event of that cluster, and a gap of 0 emits nothing.
- R5: In mode 2, the swapped event word w gives four samples in the order n = 0, 1, 2, 3. Bit k of sample n (k = 0..3) is w[4k+n], and bits 15:4 are 0.
- R6: In mode 1, the swapped event word w gives two samples in the order n = 0, 1. Bit k of sample n (k = 0..7) is w[2k+n], and bits 15:8 are 0.
- R7: In modes 1 and 2, each missing event in a gap becomes 2 or 4 padding samples respectively.
- R8: The header field `cl_nevents` (1 to 7) sets how many event words follow. After the last of them the block accepts a header again. The expected timestamp always becomes the header's timestamp + 7, even for a partly filled cluster.
- R9: While `smp_valid` is 1 and `smp_ready` is 0, `smp_data` holds its value and no sample is lost or repeated.
- R10: The sample used for padding is the last sample emitted for an event, carried across clusters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0: one sample per event, 1: two, 2: four, 3: same as 0 |
| cl_valid | input | 1 | Cluster word valid |
| cl_ready | output | 1 | Cluster word accepted when high with valid |
| cl_word | input | 16 | Timestamp (header) or byte-swapped event word |
| cl_head | input | 1 | Word is a cluster header |
| cl_start | input | 1 | Header starts a new capture |
| cl_nevents | input | 3 | Header: number of event words that follow (1 to 7) |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Output sample accepted |
| smp_data | output | 16 | Output sample |

## Verification
The assertions take three things about the input stream as given. Every header announces between one and seven events. Exactly that many non-header words follow it. The mode stays fixed for the whole of a capture. The stimulus builds each cluster as one header followed by its announced number of event words. It changes the mode only after a start header, and it keeps gaps small so that padding runs stay short. Backpressure is applied as a repeating stall pattern while a quad-rate cluster with a gap is unpacked.

// File: rtl/cluster_expander.sv
module cluster_expander #(
  parameter int TS_W   = 16,
  parameter int EVENTS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        cl_valid,
  output logic        cl_ready,
  input  logic [15:0] cl_word,
  input  logic        cl_head,
  input  logic        cl_start,
  input  logic [2:0]  cl_nevents,
  output logic        smp_valid,
  input  logic        smp_ready,
  output logic [15:0] smp_data
);
  localparam int EW = $clog2(EVENTS + 1);

  typedef enum logic [1:0] {S_HEAD, S_PAD, S_EVT} state_t;
  state_t state;

  logic [TS_W-1:0] exp_ts, pad_left, gap;
  logic [15:0]     last, hold, shifted, evt_sample;
  logic            hold_full;
  logic [1:0]      sub, spe_m1;
  logic [EW-1:0]   ev_left;

  wire head_fire = cl_valid && cl_ready && state == S_HEAD && cl_head;
  wire word_fire = cl_valid && cl_ready && state == S_EVT;
  wire out_fire  = smp_valid && smp_ready;
  wire sub_last  = sub == spe_m1;

  assign spe_m1    = (mode == 2'd1) ? 2'd1 : (mode == 2'd2) ? 2'd3 : 2'd0;
  assign gap       = cl_start ? '0 : cl_word[TS_W-1:0] - exp_ts;
  assign cl_ready  = state == S_HEAD || (state == S_EVT && !hold_full);
  assign smp_valid = state == S_PAD || (state == S_EVT && hold_full);
  assign shifted   = hold >> sub;
  assign smp_data  = (state == S_PAD) ? last : evt_sample;

  always_comb begin
    evt_sample = '0;
    case (mode)
      2'd1: for (int k = 0; k < 8; k++) evt_sample[k] = shifted[2*k];
      2'd2: for (int k = 0; k < 4; k++) evt_sample[k] = shifted[4*k];
      default: evt_sample = hold;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_HEAD;
      exp_ts    <= '0;
      pad_left  <= '0;
      last      <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      sub       <= '0;
      ev_left   <= '0;
    end else begin
      case (state)
        S_HEAD: if (head_fire) begin
          exp_ts   <= cl_word[TS_W-1:0] + TS_W'(EVENTS);
          pad_left <= gap;
          sub      <= '0;
          ev_left  <= EW'(cl_nevents);
          if (cl_start) last <= '0;
          state    <= (gap != '0) ? S_PAD : S_EVT;
        end
        S_PAD: if (out_fire) begin
          if (sub_last) begin
            sub      <= '0;
            pad_left <= pad_left - 1'b1;
            if (pad_left == TS_W'(1)) state <= S_EVT;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        S_EVT: begin
          if (word_fire) begin
            hold      <= {cl_word[7:0], cl_word[15:8]};
            hold_full <= 1'b1;
            sub       <= '0;
          end
          if (out_fire) begin
            last <= evt_sample;
            if (sub_last) begin
              sub       <= '0;
              hold_full <= 1'b0;
              ev_left   <= ev_left - 1'b1;
              if (ev_left == EW'(1)) state <= S_HEAD;
            end else begin
              sub <= sub + 1'b1;
            end
          end
        end
        default: state <= S_HEAD;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !smp_valid && cl_ready);

  p_head_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    head_fire |-> cl_nevents != 3'd0 && int'(cl_nevents) <= EVENTS);

  p_head_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    head_fire |=> state != S_HEAD);

  p_pad_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PAD && $past(state == S_PAD) |-> $stable(smp_data));

  p_quad_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_EVT && smp_valid && mode == 2'd2 |-> smp_data[15:4] == 12'd0);

  p_dual_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_EVT && smp_valid && mode == 2'd1 |-> smp_data[15:8] == 8'd0);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data));

  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> !(cl_ready && state == S_EVT));
endmodule

// File: tb/cluster_expander_test.sv
module cluster_expander_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic cl_valid = 0, cl_head = 0, cl_start = 0, smp_ready = 1;
  logic [15:0] cl_word = 0;
  logic [2:0] cl_nevents = 0;
  logic cl_ready, smp_valid;
  logic [15:0] smp_data;

  always #5 clk = ~clk;

  cluster_expander uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cl_valid(cl_valid), .cl_ready(cl_ready),
    .cl_word(cl_word), .cl_head(cl_head), .cl_start(cl_start), .cl_nevents(cl_nevents),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data));

  int checks = 0, fails = 0;
  logic [15:0] expv [0:4095];
  logic [15:0] got  [0:4095];
  int n_exp = 0, n_got = 0;
  logic [15:0] m_exp = 0, m_last = 0;
  logic [15:0] ev_w [0:6];
  bit stall_on = 0;
  int stall_cnt = 0;

  always @(negedge clk)
    if (rst_n && smp_valid && smp_ready) begin
      if (n_got < 4096) got[n_got] = smp_data;
      n_got++;
    end

  always @(posedge clk) begin
    #2;
    stall_cnt++;
    smp_ready = stall_on ? (stall_cnt % 3 == 0) : 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] expd);
    checks++;
    if (act !== expd) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
    end
  endtask

  task automatic push(logic [15:0] v);
    expv[n_exp] = v;
    n_exp++;
  endtask

  task automatic put(logic [15:0] w, bit head, bit start, logic [2:0] n);
    cl_valid = 1; cl_word = w; cl_head = head; cl_start = start; cl_nevents = n;
    #1;
    while (!cl_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cl_valid = 0; cl_head = 0; cl_start = 0;
  endtask

  task automatic cluster(bit start, logic [15:0] ts, int n);
    int spe;
    logic [15:0] gap;
    spe = (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
    if (start) begin m_exp = ts; m_last = 0; end
    gap = ts - m_exp;
    for (int i = 0; i < int'(gap) * spe; i++) push(m_last);
    for (int e = 0; e < n; e++) begin
      logic [15:0] w;
      w = {ev_w[e][7:0], ev_w[e][15:8]};
      for (int s = 0; s < spe; s++) begin
        logic [15:0] v;
        v = 0;
        if (spe == 1) v = w;
        else for (int b = 0; b < 16 / spe; b++) v[b] = w[spe * b + s];
        push(v);
        m_last = v;
      end
    end
    m_exp = ts + 16'd7;
    put(ts, 1, start, n[2:0]);
    for (int e = 0; e < n; e++) put(ev_w[e], 0, 0, 0);
  endtask

  task automatic drain_and_compare(string req);
    int t = 0;
    while (n_got < n_exp && t < 5000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    check({req, " count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) check(req, got[i], expv[i]);
    n_exp = 0; n_got = 0;
  endtask

  task automatic fill_events(logic [15:0] seed);
    for (int i = 0; i < 7; i++) ev_w[i] = seed * 16'(i + 3) ^ 16'h5a3c ^ 16'(i << 11);
  endtask

  task automatic t_reset;
    check("R1 smp_valid", smp_valid, 0);
    check("R1 cl_ready", cl_ready, 1);
  endtask

  task automatic t_single_rate;
    mode = 0;
    fill_events(16'h1234);
    ev_w[0] = 16'hab12;
    cluster(1, 16'hfff0, 7);
    drain_and_compare("R2 R3 start cluster, swap");
    fill_events(16'h0777);
    cluster(0, 16'hfff7, 7);
    drain_and_compare("R4 adjacent cluster no padding");
    fill_events(16'h0101);
    cluster(0, 16'h0003, 3);
    drain_and_compare("R4 R10 wrapped gap padding with last sample");
    fill_events(16'h2222);
    cluster(0, 16'h000c, 2);
    drain_and_compare("R8 partial cluster advances by 7");
  endtask

  task automatic t_dual_rate;
    mode = 1;
    fill_events(16'h3c3c);
    cluster(1, 16'h0100, 4);
    drain_and_compare("R6 two samples per event");
    fill_events(16'h0f1e);
    cluster(0, 16'h0109, 2);
    drain_and_compare("R7 R10 dual-rate padding x2");
  endtask

  task automatic t_quad_rate;
    mode = 2;
    fill_events(16'hc0de);
    ev_w[0] = 16'h0180;
    cluster(1, 16'h4000, 5);
    drain_and_compare("R5 four samples per event");
    fill_events(16'h7171);
    cluster(0, 16'h400a, 3);
    drain_and_compare("R7 quad-rate padding x4");
  endtask

  task automatic t_backpressure;
    mode = 2;
    stall_on = 1;
    fill_events(16'hbeef);
    cluster(1, 16'h0020, 7);
    fill_events(16'h1357);
    cluster(0, 16'h002a, 6);
    drain_and_compare("R9 stalled output keeps every sample");
    stall_on = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single_rate();
    t_dual_rate();
    t_quad_rate();
    t_backpressure();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule